// File: doc/BRIEF.md
# Three-Wire Register Configuration Master

This block lets a processor read and write the 8-bit control registers of a baseband chip over a three-wire serial link. The link has a serial clock, one shared data line and an active-low chip select. The link has no read/write strobe. The top bit of the address picks the direction, and address and data travel one after the other on the same line. For reads, the line is turned around partway through the frame.

Software writes a 17-bit command word. Bits 7:0 hold the write data, bits 15:8 hold the register address, and bit 16 is set to start the transfer. The hardware keeps bit 16 set while the frame is on the wire and clears it when the frame has ended. Software polls that bit before it issues the next command. The byte returned by a read appears on a separate read-data output. The serial clock comes from the system clock through a parameterised divider: each half period lasts `HALF_DIV` system cycles.

Top module: `tw_reg_master`

## Requirements
- R1: The chip select `ser_cs_n` is low for the whole frame, and the serial clock `ser_clk` stays low whenever `ser_cs_n` is high.
- R2: Each frame has exactly 16 rising edges of `ser_clk`. The 8 address bits come first, then 8 data bits, each most significant bit first.
- R3: When address bit 7 is 1 the frame is a write, and the master drives command bits 7:0 as the data byte.
- R4: When address bit 7 is 0 the frame is a read. `ser_oe` goes low after the eighth falling edge of `ser_clk`. The master samples `ser_di` on rising edges 9 to 16 and presents that byte on `rd_data` once the frame has ended.
- R5: `ser_do` changes only at falling transitions of `ser_clk`, so it is stable across every rising edge.
- R6: A `cmd_wr` pulse with bit 16 set, while idle, starts a frame. `cmd_rd` bit 16 reads 1 from the next cycle until the transfer finishes, and bits 15:0 read back the accepted address and data.
- R7: A `cmd_wr` pulse while busy is ignored. The frame in progress and `cmd_rd` bits 15:0 are unchanged.
- R8: A `cmd_wr` pulse with bit 16 clear starts nothing. Busy stays 0, `cmd_rd` is unchanged and no frame appears.
- R9: Between frames `ser_cs_n` stays high for at least `2*HALF_DIV` system cycles, and busy clears at the end of that gap.
- R10: Within a frame, successive rising edges of `ser_clk` are exactly `2*HALF_DIV` system cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | One-cycle write strobe for the command word |
| cmd_wdata | input | 17 | Command: [16] start, [15:8] address, [7:0] data |
| cmd_rd | output | 17 | Command readback: [16] busy, [15:0] accepted address and data |
| rd_data | output | 8 | Byte returned by the last read frame |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_cs_n | output | 1 | Active-low chip select |
| ser_do | output | 1 | Serial data out (data line driver value) |
| ser_oe | output | 1 | Data line driver enable |
| ser_di | input | 1 | Serial data in from the data line |

## Verification
The bench builds the block with `HALF_DIV=2`. A frame then takes about 70 system cycles, which is short enough to write every register index from 0 to 127 and then read each one back. Every address pattern passes through the MSB-first framing in both directions. The bench contains a behavioural target that decodes the line on each clock transition and answers reads from its own register array. The bench also measures the edge spacing and the gap length in system cycles against `2*HALF_DIV`, and it injects commands in mid-frame and with the start bit clear.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int FRAME_BITS = 16;
  localparam int BYTE_BITS  = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } tw_state_e;

  typedef struct packed {
    logic                 start;
    logic [BYTE_BITS-1:0] addr;
    logic [BYTE_BITS-1:0] data;
  } tw_cmd_t;
endpackage

// File: rtl/tw_sclk_div.sv
module tw_sclk_div #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tw_frame_ctl.sv
module tw_frame_ctl
  import tw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [BYTE_BITS-1:0] addr,
  input  logic [BYTE_BITS-1:0] wdata,
  input  logic                 tick,
  input  logic                 sdi,
  output logic                 run,
  output logic                 done,
  output logic                 rx_valid,
  output logic [BYTE_BITS-1:0] rx_byte,
  output logic                 sclk,
  output logic                 cs_n,
  output logic                 sdo,
  output logic                 oe
);
  tw_state_e             st_q;
  logic [FRAME_BITS-1:0] tx_q;
  logic [3:0]            bit_q;
  logic                  is_wr_q;
  logic                  gap_q;

  assign run = (st_q != ST_IDLE);
  assign sdo = oe & tx_q[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      tx_q     <= '0;
      bit_q    <= '0;
      is_wr_q  <= 1'b0;
      gap_q    <= 1'b0;
      sclk     <= 1'b0;
      cs_n     <= 1'b1;
      oe       <= 1'b0;
      done     <= 1'b0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      done     <= 1'b0;
      rx_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q    <= ST_SHIFT;
          tx_q    <= {addr, wdata};
          is_wr_q <= addr[BYTE_BITS-1];
          bit_q   <= '0;
          cs_n    <= 1'b0;
          oe      <= 1'b1;
          sclk    <= 1'b0;
        end
        ST_SHIFT: if (tick) begin
          if (!sclk) begin
            sclk <= 1'b1;
            if (!is_wr_q && bit_q[3]) rx_byte <= {rx_byte[BYTE_BITS-2:0], sdi};
          end else begin
            sclk <= 1'b0;
            if (bit_q == 4'd15) begin
              st_q  <= ST_GAP;
              cs_n  <= 1'b1;
              oe    <= 1'b0;
              gap_q <= 1'b0;
            end else begin
              bit_q <= bit_q + 4'd1;
              tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b0};
              oe    <= is_wr_q || (bit_q < 4'd7);
            end
          end
        end
        ST_GAP: if (tick) begin
          gap_q <= 1'b1;
          if (gap_q) begin
            st_q     <= ST_IDLE;
            done     <= 1'b1;
            rx_valid <= !is_wr_q;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tw_reg_master.sv
module tw_reg_master
  import tw_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [16:0] cmd_wdata,
  output logic [16:0] cmd_rd,
  output logic [7:0]  rd_data,
  output logic        ser_clk,
  output logic        ser_cs_n,
  output logic        ser_do,
  output logic        ser_oe,
  input  logic        ser_di
);
  tw_cmd_t        cmd_in;
  logic           busy_q;
  logic [7:0]     addr_q, data_q, rd_q;
  logic           accept, run, tick, done, rx_valid;
  logic [7:0]     rx_byte;

  assign cmd_in = cmd_wdata;
  assign accept = cmd_wr && cmd_in.start && !busy_q;
  assign cmd_rd  = {busy_q, addr_q, data_q};
  assign rd_data = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= '0;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        addr_q <= cmd_in.addr;
        data_q <= cmd_in.data;
      end else if (done) begin
        busy_q <= 1'b0;
      end
      if (rx_valid) rd_q <= rx_byte;
    end
  end

  tw_sclk_div #(.HALF_DIV(HALF_DIV)) div_i (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  tw_frame_ctl ctl_i (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .addr(cmd_in.addr), .wdata(cmd_in.data),
    .tick(tick), .sdi(ser_di), .run(run), .done(done),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .sclk(ser_clk), .cs_n(ser_cs_n), .sdo(ser_do), .oe(ser_oe)
  );
endmodule

// File: rtl/tw_reg_master_chk.sv
module tw_reg_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic [16:0] cmd_rd,
  input logic        ser_clk,
  input logic        ser_cs_n,
  input logic        ser_do,
  input logic        ser_oe
);
  a_r1_clk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    ser_cs_n |-> !ser_clk);

  a_r5_do_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> $stable(ser_do));

  a_r6_busy_covers_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_cs_n |-> cmd_rd[16]);

  a_r7_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_rd[16]) |=> (cmd_rd[15:0] == $past(cmd_rd[15:0])));

  a_r4_no_drive_outside: assert property (@(posedge clk) disable iff (!rst_n)
    ser_cs_n |-> !ser_oe);

  a_r9_gap_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_cs_n) |=> ser_cs_n);
endmodule

bind tw_reg_master tw_reg_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
  .ser_clk(ser_clk), .ser_cs_n(ser_cs_n), .ser_do(ser_do), .ser_oe(ser_oe)
);

// File: tb/tw_reg_master_tb_top.sv
module tw_reg_master_tb_top;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [16:0] cmd_wdata = '0;
  logic [16:0] cmd_rd;
  logic [7:0]  rd_data;
  logic        ser_clk, ser_cs_n, ser_do, ser_oe;
  logic        ser_di = 1'b0;

  tw_reg_master #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rd(cmd_rd), .rd_data(rd_data), .ser_clk(ser_clk),
    .ser_cs_n(ser_cs_n), .ser_do(ser_do), .ser_oe(ser_oe), .ser_di(ser_di)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Behavioural serial target
  logic [7:0] mem [128];
  logic p_clk = 0, p_cs = 1, p_do = 0;
  int   nbits = 0, gap = 0, last_rise = 0, frames = 0;
  logic [7:0] t_addr = 0, t_dat = 0, last_addr = 0, last_dat = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_cs_n) begin
        gap++;
        chk(!ser_clk, "R1 clk low while cs high", ser_clk, 0);
      end
      if (p_cs && !ser_cs_n) begin
        if (frames > 0) chk(gap >= 2*HALF, "R9 gap length", gap, 2*HALF);
        nbits = 0;
      end
      if (!ser_cs_n && !p_clk && ser_clk) begin
        chk(ser_do == p_do, "R5 data stable at rise", ser_do, p_do);
        if (nbits > 0) chk(cyc - last_rise == 2*HALF, "R10 edge spacing", cyc - last_rise, 2*HALF);
        last_rise = cyc;
        if (nbits < 8) t_addr = {t_addr[6:0], ser_do};
        else if (t_addr[7]) t_dat = {t_dat[6:0], ser_do};
        else chk(!ser_oe, "R4 line released", ser_oe, 0);
        nbits++;
      end
      if (!ser_cs_n && p_clk && !ser_clk && !t_addr[7] && nbits >= 8 && nbits < 16)
        ser_di <= mem[t_addr[6:0]][15 - nbits];
      if (!p_cs && ser_cs_n) begin
        chk(nbits == 16, "R2 rising edges per frame", nbits, 16);
        if (t_addr[7]) mem[t_addr[6:0]] = t_dat;
        last_addr = t_addr;
        last_dat = t_dat;
        frames++;
        gap = 0;
      end
    end
    p_clk = ser_clk; p_cs = ser_cs_n; p_do = ser_do;
  end

  task automatic issue(input logic [16:0] w);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (cmd_rd[16] && n < 2000) begin @(negedge clk); n++; end
    chk(n < 2000, "R9 busy clears", n, 0);
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(ser_cs_n == 1 && ser_clk == 0 && ser_oe == 0 && cmd_rd == 0,
        "R1 reset state", {ser_cs_n, ser_clk, ser_oe}, 3'b100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: write every register index
    for (int a = 0; a < 128; a++) begin
      issue({1'b1, 8'(a | 128), pat(a)});
      chk(cmd_rd[16] == 1'b1, "R6 busy after accept", cmd_rd[16], 1);
      chk(cmd_rd[15:0] == {8'(a | 128), pat(a)}, "R6 readback", cmd_rd[15:0], {8'(a | 128), pat(a)});
      wait_idle();
      chk(last_addr == 8'(a | 128), "R2 address decoded", last_addr, a | 128);
      chk(last_dat == pat(a), "R3 write data", last_dat, pat(a));
    end

    // R4: read every register index back
    for (int a = 0; a < 128; a++) begin
      issue({1'b1, 8'(a), 8'h5A});
      wait_idle();
      chk(rd_data == pat(a), "R4 read data", rd_data, pat(a));
    end

    // R7: command while busy
    begin
      int f0;
      f0 = frames;
      issue({1'b1, 8'h85, 8'hAA});
      repeat (3) @(negedge clk);
      issue({1'b1, 8'h86, 8'h55});
      wait_idle();
      repeat (20) @(negedge clk);
      chk(frames == f0 + 1, "R7 one frame only", frames - f0, 1);
      chk(last_addr == 8'h85 && last_dat == 8'hAA, "R7 frame undisturbed", {last_addr, last_dat}, 16'h85AA);
      chk(cmd_rd[15:0] == 16'h85AA, "R7 readback unchanged", cmd_rd[15:0], 16'h85AA);
    end

    // R8: start bit clear
    begin
      int f0;
      f0 = frames;
      issue({1'b0, 8'h87, 8'h99});
      chk(cmd_rd[16] == 1'b0, "R8 busy stays low", cmd_rd[16], 0);
      repeat (50) @(negedge clk);
      chk(frames == f0 && ser_cs_n, "R8 no frame", frames - f0, 0);
      chk(cmd_rd[15:0] == 16'h85AA, "R8 readback unchanged", cmd_rd[15:0], 16'h85AA);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule